// File: doc/BRIEF.md
# Banked Multi-Width Register File

This block holds the general-purpose registers of a processor core as eight banks of sixteen bytes. A bank-select input chooses the bank for the register ports. A register access can be one byte, a 16-bit pair of adjacent bytes, a 24-bit extended value or a 32-bit double pair. A context-save strobe stores a 20-bit program counter and a 16-bit status word into two fixed pairs of the selected bank in one clock.

The same 128 bytes also appear as ordinary data memory. They sit in a 128-byte window whose base moves between two addresses under a relocation control input. The memory side is a byte-wide request/response stream. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the single response slot is empty or is being drained in the same cycle. A read answers one cycle after acceptance, and `rsp_data` holds steady while `rsp_valid` is high and `rsp_ready` is low. Writes produce no response.

Top module: `banked_regfile`

## Requirements
- R1: Eight banks are independent. `bank_sel` picks the bank used by the register read port, the register write port and the context save. A write to one bank leaves every other bank unchanged.
- R2: Width code 0 is a byte access. `idx` k (0..15) addresses register Rk, carried in data bits [7:0]. Read bits above the access width are zero.
- R3: Width code 1 is a pair access. `idx[2:0]` = p uses byte R(2p) as bits [7:0] and R(2p+1) as bits [15:8]. Pair 0 is therefore R1:R0.
- R4: Width code 2 is a 24-bit extended access. `idx[1:0]` = e uses pair 4+e as bits [15:0] and byte R(4+e) as bits [23:16]. One access reads or writes all three bytes.
- R5: Width code 3 is a 32-bit access. Pair 1 is bits [31:16] and pair 0 is bits [15:0], whatever `idx` is.
- R6: With `win_reloc`=0 the window base is 0x00FE80, and with `win_reloc`=1 it is 0xFFFE80. Window offset o maps to bank o[6:4], register o[3:0]. Memory reads and writes use the same bytes as the register ports.
- R7: A memory write outside the active window changes nothing. A memory read outside the window is answered with 0x00.
- R8: When `ctx_save` is high, the selected bank is updated at the clock edge. R4 = pc[7:0], R5 = pc[15:8], R6 = psw[7:0] and R7 = {psw[15:12], pc[19:16]}. Status bits [11:8] are not stored.
- R9: When several sources write the same byte in one cycle, the context save wins over the register write port, and the register write port wins over the memory port.
- R10: A read in the same cycle as a write to the same byte returns the value from before the write. This holds for both the register port and the memory port.
- R11: A read response appears one cycle after acceptance. While stalled, it holds valid and data, and `req_ready` stays low.
- R12: Synchronous reset clears every byte to zero and empties the response slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | 3 | Bank for register ports and context save |
| rd_width | input | 2 | Read width code (0 byte, 1 pair, 2 extended, 3 double pair) |
| rd_idx | input | 4 | Read register / pair / extended index |
| rd_data | output | 32 | Combinational read data, zero above access width |
| wr_en | input | 1 | Register write enable |
| wr_width | input | 2 | Write width code |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| ctx_save | input | 1 | Context-save strobe |
| ctx_pc | input | 20 | Program counter to save |
| ctx_psw | input | 16 | Status word to save |
| win_reloc | input | 1 | Selects the high window base |
| req_valid | input | 1 | Memory request valid |
| req_ready | output | 1 | Memory request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read response byte |

## Verification
The bench checks byte ordering inside pairs and extended values. A design that swapped the two halves of a pair, or took the extension byte from the wrong register, would return bytes in the wrong positions. It drives a register write and a memory write into the same byte in one cycle, and a context save together with a register write. A wrong priority would leave the losing value stored. It reads a byte in the same cycle it is written, where a bypass would leak the new value. It writes at the non-relocated address while the window is relocated, which a loose window decoder would let through. It holds the response stalled across a second request to catch a dropped or overwritten response.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_PAIR = 2'd1,
    W_EXT  = 2'd2,
    W_QUAD = 2'd3
  } rf_width_e;

  localparam int LANES      = 4;
  localparam int CTX_FIRST  = 4;   // first byte of the saved-PC pair
  localparam int EXT_PAIR0  = 4;   // first pair used by extended access
  localparam int EXT_BYTE0  = 4;   // first extension byte
endpackage

// File: rtl/rf_lane_map.sv
module rf_lane_map
  import rf_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic [1:0]                   width,
  input  logic [3:0]                   idx,
  output logic [LANES-1:0][REG_W-1:0]  lane_off,
  output logic [LANES-1:0]             lane_en
);
  rf_width_e w;
  assign w = rf_width_e'(width);

  always_comb begin
    lane_off = '0;
    lane_en  = '0;
    unique case (w)
      W_BYTE: begin
        lane_off[0] = REG_W'(idx);
        lane_en     = 4'b0001;
      end
      W_PAIR: begin
        lane_off[0] = REG_W'({idx[2:0], 1'b0});
        lane_off[1] = REG_W'({idx[2:0], 1'b1});
        lane_en     = 4'b0011;
      end
      W_EXT: begin
        lane_off[0] = REG_W'(2 * EXT_PAIR0 + 2 * int'(idx[1:0]));
        lane_off[1] = REG_W'(2 * EXT_PAIR0 + 2 * int'(idx[1:0]) + 1);
        lane_off[2] = REG_W'(EXT_BYTE0 + int'(idx[1:0]));
        lane_en     = 4'b0111;
      end
      W_QUAD: begin
        for (int l = 0; l < LANES; l++) lane_off[l] = REG_W'(l);
        lane_en = 4'b1111;
      end
      default: lane_en = '0;
    endcase
  end
endmodule

// File: rtl/rf_window_decode.sv
module rf_window_decode #(
  parameter int          ADDR_W  = 24,
  parameter int          OFF_W   = 7,
  parameter logic [23:0] BASE_LO = 24'h00FE80,
  parameter logic [23:0] BASE_HI = 24'hFFFE80
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              reloc,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);
  localparam int TAG_W = ADDR_W - OFF_W;
  logic [TAG_W-1:0] base_tag;

  assign base_tag = reloc ? BASE_HI[ADDR_W-1:OFF_W] : BASE_LO[ADDR_W-1:OFF_W];
  assign hit      = (addr[ADDR_W-1:OFF_W] == base_tag);
  assign off      = addr[OFF_W-1:0];
endmodule

// File: rtl/rf_store.sv
module rf_store
  import rf_pkg::*;
#(
  parameter int BANKS = 8,
  parameter int REGS  = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [$clog2(BANKS)-1:0]          bank,
  input  logic                              wr_en,
  input  logic [LANES-1:0][$clog2(REGS)-1:0] wr_off,
  input  logic [LANES-1:0]                  wr_lane_en,
  input  logic [8*LANES-1:0]                wr_data,
  input  logic [LANES-1:0][$clog2(REGS)-1:0] rd_off,
  input  logic [LANES-1:0]                  rd_lane_en,
  output logic [8*LANES-1:0]                rd_data,
  input  logic                              ctx_en,
  input  logic [8*LANES-1:0]                ctx_data,
  input  logic                              mem_we,
  input  logic [$clog2(BANKS*REGS)-1:0]     mem_waddr,
  input  logic [7:0]                        mem_wdata,
  input  logic [$clog2(BANKS*REGS)-1:0]     mem_raddr,
  output logic [7:0]                        mem_rdata
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int REG_W  = $clog2(REGS);
  localparam int BYTES  = BANKS * REGS;
  localparam int IDX_W  = $clog2(BYTES);

  logic [8*BYTES-1:0] flat;

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    localparam int R = i % REGS;
    localparam int B = i / REGS;
    logic       chit, rhit, mhit;
    logic [7:0] cdat, rdat, q;

    if (R >= CTX_FIRST && R < CTX_FIRST + LANES) begin : g_ctx
      assign chit = ctx_en && (bank == BANK_W'(B));
      assign cdat = ctx_data[8*(R-CTX_FIRST) +: 8];
    end else begin : g_noctx
      assign chit = 1'b0;
      assign cdat = 8'h00;
    end

    always_comb begin
      rhit = 1'b0;
      rdat = 8'h00;
      for (int l = 0; l < LANES; l++) begin
        if (wr_en && wr_lane_en[l] && ({bank, wr_off[l]} == IDX_W'(i))) begin
          rhit = 1'b1;
          rdat = wr_data[8*l +: 8];
        end
      end
    end

    assign mhit = mem_we && (mem_waddr == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst)       q <= 8'h00;
      else if (chit) q <= cdat;
      else if (rhit) q <= rdat;
      else if (mhit) q <= mem_wdata;
    end

    assign flat[8*i +: 8] = q;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rd_data[8*l +: 8] = rd_lane_en[l]
        ? flat[{bank, rd_off[l], 3'b000} +: 8] : 8'h00;
    end
  end

  assign mem_rdata = flat[{mem_raddr, 3'b000} +: 8];

  logic unused_reg_w;
  assign unused_reg_w = (REG_W == 0);
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int          BANKS   = 8,
  parameter int          REGS    = 16,
  parameter int          ADDR_W  = 24,
  parameter int          PC_W    = 20,
  parameter int          PSW_W   = 16,
  parameter logic [23:0] BASE_LO = 24'h00FE80,
  parameter logic [23:0] BASE_HI = 24'hFFFE80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bank_sel,
  input  logic [1:0]        rd_width,
  input  logic [3:0]        rd_idx,
  output logic [31:0]       rd_data,
  input  logic              wr_en,
  input  logic [1:0]        wr_width,
  input  logic [3:0]        wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              ctx_save,
  input  logic [19:0]       ctx_pc,
  input  logic [15:0]       ctx_psw,
  input  logic              win_reloc,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [23:0]       req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int REG_W  = $clog2(REGS);
  localparam int IDX_W  = $clog2(BANKS * REGS);

  logic [LANES-1:0][REG_W-1:0] rd_off, wr_off;
  logic [LANES-1:0]            rd_len, wr_len;

  rf_lane_map #(.REG_W(REG_W)) u_rd_map (
    .width(rd_width), .idx(rd_idx), .lane_off(rd_off), .lane_en(rd_len)
  );
  rf_lane_map #(.REG_W(REG_W)) u_wr_map (
    .width(wr_width), .idx(wr_idx), .lane_off(wr_off), .lane_en(wr_len)
  );

  logic             win_hit;
  logic [IDX_W-1:0] win_off;

  rf_window_decode #(
    .ADDR_W(ADDR_W), .OFF_W(IDX_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
  ) u_win (
    .addr(req_addr), .reloc(win_reloc), .hit(win_hit), .off(win_off)
  );

  // Context word: saved-PC pair low, then status pair with the PC top
  // nibble standing in for the dropped status bits.
  logic [31:0] ctx_word;
  assign ctx_word = {ctx_psw[PSW_W-1:PSW_W-4], ctx_pc[PC_W-1:PC_W-4],
                     ctx_psw[7:0], ctx_pc[15:0]};

  logic       rsp_valid_q;
  logic [7:0] rsp_data_q;
  logic       accept, mem_we;
  logic [7:0] mem_rdata;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign mem_we    = accept && req_write && win_hit;

  rf_store #(.BANKS(BANKS), .REGS(REGS)) u_store (
    .clk(clk), .rst(rst), .bank(bank_sel[BANK_W-1:0]),
    .wr_en(wr_en), .wr_off(wr_off), .wr_lane_en(wr_len), .wr_data(wr_data),
    .rd_off(rd_off), .rd_lane_en(rd_len), .rd_data(rd_data),
    .ctx_en(ctx_save), .ctx_data(ctx_word),
    .mem_we(mem_we), .mem_waddr(win_off), .mem_wdata(req_wdata),
    .mem_raddr(win_off), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= 8'h00;
    end else if (accept && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= win_hit ? mem_rdata : 8'h00;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  logic unused_psw;
  assign unused_psw = ^ctx_psw[11:8];
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter logic [23:0] BASE_LO = 24'h00FE80,
  parameter logic [23:0] BASE_HI = 24'hFFFE80
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [23:0] req_addr,
  input logic        win_reloc,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_data,
  input logic [31:0] rd_data
);
  logic in_win;
  assign in_win = win_reloc ? (req_addr[23:7] == BASE_HI[23:7])
                            : (req_addr[23:7] == BASE_LO[23:7]);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R11
  rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write));

  // R7
  outside_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write && !in_win) |=> (rsp_data == 8'h00));

  // R12
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == 32'h0 && !rsp_valid));
endmodule

bind banked_regfile banked_regfile_chk #(.BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .win_reloc(win_reloc),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rd_data(rd_data)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  bank_sel;
  logic [1:0]  rd_width, wr_width;
  logic [3:0]  rd_idx, wr_idx;
  logic [31:0] rd_data, wr_data;
  logic        wr_en, ctx_save, win_reloc;
  logic [19:0] ctx_pc;
  logic [15:0] ctx_psw;
  logic        req_valid, req_ready, req_write, rsp_valid, rsp_ready;
  logic [23:0] req_addr;
  logic [7:0]  req_wdata, rsp_data;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [128];
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  banked_regfile uut (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .rd_width(rd_width),
    .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en), .wr_width(wr_width),
    .wr_idx(wr_idx), .wr_data(wr_data), .ctx_save(ctx_save), .ctx_pc(ctx_pc),
    .ctx_psw(ctx_psw), .win_reloc(win_reloc), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  function automatic int lane_of(int w, int idx, int l);
    case (w)
      0: return (l == 0) ? idx : -1;
      1: return (l < 2) ? 2 * (idx % 8) + l : -1;
      2: return (l < 2) ? 8 + 2 * (idx % 4) + l : ((l == 2) ? 4 + (idx % 4) : -1);
      default: return l;
    endcase
  endfunction

  function automatic logic [31:0] model_read(int b, int w, int idx);
    logic [31:0] v = '0;
    for (int l = 0; l < 4; l++)
      if (lane_of(w, idx, l) >= 0) v[8*l +: 8] = model[16*b + lane_of(w, idx, l)];
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_check(string req, int b, int w, int idx);
    bank_sel = 3'(b); rd_width = 2'(w); rd_idx = 4'(idx);
    #1;
    check(req, rd_data, model_read(b, w, idx));
  endtask

  task automatic reg_write(int b, int w, int idx, logic [31:0] d);
    bank_sel = 3'(b); wr_width = 2'(w); wr_idx = 4'(idx); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    for (int l = 0; l < 4; l++)
      if (lane_of(w, idx, l) >= 0) model[16*b + lane_of(w, idx, l)] = d[8*l +: 8];
  endtask

  function automatic int win_off(logic [23:0] a);
    logic [23:0] base = win_reloc ? 24'hFFFE80 : 24'h00FE80;
    return (a[23:7] == base[23:7]) ? int'(a[6:0]) : -1;
  endfunction

  task automatic mem_req(logic wr, logic [23:0] a, logic [7:0] d, string req);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (!wr) begin
      exp_q.push_back(win_off(a) >= 0 ? model[win_off(a)] : 8'h00);
      tag_q.push_back(req);
    end else if (win_off(a) >= 0) model[win_off(a)] = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: sample well after the falling edge, before the rising edge
  always @(negedge clk) begin
    #2;
    if (!rst && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R11", 32'(rsp_data), 32'hFFFF_FFFF);
      else check(tag_q.pop_front(), 32'(rsp_data), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    rst = 1'b1; bank_sel = 0; rd_width = 0; rd_idx = 0; wr_en = 0; wr_width = 0;
    wr_idx = 0; wr_data = 0; ctx_save = 0; ctx_pc = 0; ctx_psw = 0; win_reloc = 0;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; rsp_ready = 1;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    reg_check("R12", 0, 3, 0);
    reg_check("R12", 7, 2, 3);
    check("R12", 32'(rsp_valid), 0);

    // R2 byte access, R3 pair ordering
    reg_write(0, 0, 3, 32'hFFFF_FF5A);
    reg_check("R2", 0, 0, 3);
    reg_write(0, 1, 0, 32'h0000_B1C0);
    reg_check("R3", 0, 0, 1);
    reg_check("R3", 0, 0, 0);
    reg_check("R3", 0, 1, 0);
    // R4 extended, R5 double pair
    reg_write(1, 2, 2, 32'h00E3_D2C1);
    reg_check("R4", 1, 0, 6);
    reg_check("R4", 1, 0, 12);
    reg_check("R4", 1, 2, 2);
    reg_write(1, 3, 9, 32'h4433_2211);
    reg_check("R5", 1, 3, 0);
    reg_check("R5", 1, 1, 1);
    // R1 bank independence
    reg_write(2, 0, 3, 32'h0000_0077);
    reg_check("R1", 0, 0, 3);
    reg_check("R1", 2, 0, 3);

    // R6 window mapping both ways
    mem_req(1'b0, 24'h00FE80 + 24'd16 + 24'd12, 8'h00, "R6");
    mem_req(1'b1, 24'h00FE80 + 24'd48 + 24'd9, 8'h6E, "R6");
    reg_check("R6", 3, 0, 9);
    // R7 outside window
    mem_req(1'b1, 24'h00FF00, 8'hAA, "R7");
    mem_req(1'b0, 24'h00FE7F, 8'h00, "R7");
    win_reloc = 1'b1;
    mem_req(1'b1, 24'h00FE80 + 24'd48 + 24'd9, 8'h11, "R7");
    reg_check("R7", 3, 0, 9);
    mem_req(1'b0, 24'hFFFE80 + 24'd3, 8'h00, "R6");
    mem_req(1'b1, 24'hFFFE80 + 24'd112 + 24'd15, 8'hC4, "R6");
    reg_check("R6", 7, 0, 15);
    win_reloc = 1'b0;

    // R8 context save
    bank_sel = 3'd5; ctx_pc = 20'hA5C3E; ctx_psw = 16'h9B7D; ctx_save = 1'b1;
    @(negedge clk);
    ctx_save = 1'b0;
    model[84] = 8'h3E; model[85] = 8'h5C; model[86] = 8'h7D; model[87] = 8'h9A;
    reg_check("R8", 5, 1, 2);
    reg_check("R8", 5, 1, 3);

    // R9 ctx beats register write on shared byte
    bank_sel = 3'd5; ctx_pc = 20'h12345; ctx_psw = 16'hF0E1; ctx_save = 1'b1;
    wr_width = 2'd0; wr_idx = 4'd4; wr_data = 32'h99; wr_en = 1'b1;
    @(negedge clk);
    ctx_save = 1'b0; wr_en = 1'b0;
    model[84] = 8'h45; model[85] = 8'h23; model[86] = 8'hE1; model[87] = 8'hF1;
    reg_check("R9", 5, 0, 4);
    // R9 register write beats memory write
    bank_sel = 3'd6; wr_width = 2'd0; wr_idx = 4'd2; wr_data = 32'h3C; wr_en = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 24'h00FE80 + 24'd98; req_wdata = 8'hC3;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    model[98] = 8'h3C;
    reg_check("R9", 6, 0, 2);

    // R10 same-cycle read returns old value (register and memory ports)
    bank_sel = 3'd6; rd_width = 2'd0; rd_idx = 4'd2;
    wr_width = 2'd0; wr_idx = 4'd2; wr_data = 32'h5D; wr_en = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h00FE80 + 24'd98;
    #1;
    check("R10", rd_data, 32'h3C);
    exp_q.push_back(8'h3C); tag_q.push_back("R10");
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    model[98] = 8'h5D;
    reg_check("R10", 6, 0, 2);

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h00FE80 + 24'd87;
    exp_q.push_back(model[87]); tag_q.push_back("R11");
    @(negedge clk);
    req_addr = 24'h00FE80 + 24'd85;
    #1;
    check("R11", 32'(req_ready), 0);
    check("R11", 32'(rsp_valid), 1);
    held = rsp_data;
    @(negedge clk); #1;
    check("R11", 32'(rsp_data), 32'(held));
    check("R11", 32'(held), 32'(model[87]));
    exp_q.push_back(model[85]); tag_q.push_back("R11");
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;

    for (int t = 0; t < 20 && exp_q.size() != 0; t++) @(negedge clk);
    check("R11", 32'(exp_q.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule